// File: doc/BRIEF.md
# Serial SAR Converter Host Controller

This block runs single conversions on an external 10-bit successive-approximation converter over three wires. It drives a conversion-start line and a serial clock, and it reads one serial data line. A command carries a one-bit input selection, an acquisition length and a conversion wait, both counted in system clock cycles. The controller first plays a short start-line preamble that tells the converter which input or polarity to use; the preamble comes from a parameter table. It then holds the start line high for the acquisition interval and drops it. That falling edge is the sampling instant. Next it waits out the conversion and produces exactly ten serial clock pulses, capturing one bit, MSB first, on each rising edge. Finally it offers the word, tagged with the selection, on a ready/valid result port.

A state register sequences the work through seven states:
- `ST_IDLE` accepts a command and goes to `ST_SEL_HI`, or straight to `ST_ACQ` if the selection has no preamble pulses.
- `ST_SEL_HI` moves to `ST_SEL_LO` after `PULSE_CYC` cycles.
- `ST_SEL_LO` moves after `PULSE_CYC` cycles to `ST_SEL_HI` if preamble pulses remain, otherwise to `ST_ACQ`.
- `ST_ACQ` moves to `ST_CONV` once the acquisition count expires.
- `ST_CONV` moves to `ST_READ` once the conversion wait expires.
- `ST_READ` moves to `ST_DONE` on the tenth falling serial clock edge.
- `ST_DONE` returns to `ST_IDLE` when the result is accepted.

The conversion wait is a counted interval and not a watch on the data line, because a zero MSB looks the same as the busy-low level.

Top module: `sar_adc_host`

## Requirements
- R1: Out of reset and whenever `cmd_ready` is high, `cnvst`, `sclk` and `res_valid` are low. `cmd_ready` is high only in the idle state.
- R2: A command is taken only on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` stays low from the cycle after acceptance until the result has been accepted, so commands offered meanwhile have no effect.
- R3: Before acquisition, the start line plays the preamble for the selection. The pulse count for selection s is the 4-bit field s of `SEL_PULSES`; the defaults are 0 pulses for selection 0 and 1 pulse for selection 1. Each pulse is high for `PULSE_CYC` cycles and then low for `PULSE_CYC` cycles.
- R4: After the preamble, `cnvst` is high for max(acq,1) consecutive cycles and then falls. That fall is the sampling instant.
- R5: After the fall, `cnvst` and `sclk` stay low for max(conv,1) cycles before serial clocking begins.
- R6: `sclk` idles low. In a read, each phase lasts `SCLK_HALF` cycles, the low phase comes first, and there are exactly 10 rising edges. The read ends on the 10th falling edge.
- R7: `sdata` is sampled at each rising `sclk` edge. The first bit sampled becomes `res_data[9]` and the last becomes `res_data[0]`.
- R8: `res_valid` rises the cycle after the last falling edge. It stays high with `res_data` and `res_sel` stable until `res_ready` is high, so it lasts one cycle when `res_ready` is already high. `res_sel` equals the `cmd_sel` given with the command.
- R9: `sdata` activity outside the ten sampling edges does not change `res_data`.
- R10: `cnvst` and `sclk` are never high together.
- R11: `cfg_acq_cycles`, `cfg_conv_cycles` and `cmd_sel` are latched at acceptance. Changing them during a conversion does not alter its timing or tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_sel | input | 1 | Input or polarity selection for this command |
| cfg_acq_cycles | input | CNT_W | Acquisition interval in cycles (0 treated as 1) |
| cfg_conv_cycles | input | CNT_W | Conversion wait in cycles (0 treated as 1) |
| cnvst | output | 1 | Conversion-start line to the converter |
| sclk | output | 1 | Serial clock to the converter |
| sdata | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Result consumer ready |
| res_data | output | RES_W | Converted word, MSB first on the wire |
| res_sel | output | 1 | Selection tag of the result |

## Verification
The controller is tried with both selections, so runs with and without a preamble are compared cycle by cycle against an expected start-line and clock waveform. Some commands use zero acquisition and conversion counts, others longer ones, which checks the clamp to one cycle and the counted waits. The data patterns are all-ones, all-zeros, alternating bits and single set bits at either end, and these show whether the bit order and the sampling edge are right. While the converter model holds the data line low, the conversion wait is exposed: a read that starts too early would capture zeros. Toggling the released line, holding off `res_ready`, and offering a second command with altered settings while busy separate the ignore, hold and latch behaviour.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL_HI,
        ST_SEL_LO,
        ST_ACQ,
        ST_CONV,
        ST_READ,
        ST_DONE
    } host_state_e;

endpackage

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
    parameter int unsigned HALF  = 2,
    parameter int unsigned NBITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_now,
    output logic last_fall
);
    localparam int unsigned HC_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned EC_W = $clog2(NBITS + 1);
    localparam logic [HC_W-1:0] HC_LOAD = HC_W'(HALF - 1);
    localparam logic [EC_W-1:0] EC_LAST = EC_W'(NBITS);

    logic [HC_W-1:0] hc_q;
    logic [EC_W-1:0] edges_q;
    logic            sclk_q;
    logic            hit;
    logic            fall_now;

    always_comb begin
        hit       = (hc_q == '0);
        rise_now  = run && hit && !sclk_q;
        fall_now  = run && hit && sclk_q;
        last_fall = fall_now && (edges_q == EC_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc_q    <= HC_LOAD;
            edges_q <= '0;
            sclk_q  <= 1'b0;
        end else if (!run) begin
            hc_q    <= HC_LOAD;
            edges_q <= '0;
            sclk_q  <= 1'b0;
        end else if (hit) begin
            hc_q   <= HC_LOAD;
            sclk_q <= ~sclk_q;
            if (!sclk_q) begin
                edges_q <= edges_q + 1'b1;
            end
        end else begin
            hc_q <= hc_q - 1'b1;
        end
    end

    assign sclk = sclk_q;

    // Never more rising edges than result bits in one read.
    assert_edge_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        edges_q <= EC_LAST);

    // Clock returns low once the final bit has been clocked.
    assert_stop_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last_fall |=> !sclk_q);

endmodule

// File: rtl/sar_shift_in.sv
module sar_shift_in #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         din,
    output logic [W-1:0] word
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (capture) begin
            sh_q <= {sh_q[W-2:0], din};
        end
    end

    assign word = sh_q;

    // Register moves only on a sampling edge; idle data-line activity is ignored.
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(sh_q));

endmodule

// File: rtl/sar_adc_host.sv
module sar_adc_host
    import sar_host_pkg::*;
#(
    parameter int unsigned RES_W      = 10,
    parameter int unsigned SCLK_HALF  = 2,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned PULSE_CYC  = 2,
    parameter int unsigned PW         = 4,
    parameter logic [2*PW-1:0] SEL_PULSES = {4'd1, 4'd0}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_sel,
    input  logic [CNT_W-1:0] cfg_acq_cycles,
    input  logic [CNT_W-1:0] cfg_conv_cycles,
    output logic             cnvst,
    output logic             sclk,
    input  logic             sdata,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [RES_W-1:0] res_data,
    output logic             res_sel
);
    localparam int unsigned N_SEL = 2;
    localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYC - 1);

    host_state_e      state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [PW-1:0]    pulses_q, pulses_n;
    logic [CNT_W-1:0] acq_q, conv_q;
    logic             accept;
    logic             rd_run;
    logic             rise_now;
    logic             last_fall;
    logic [RES_W-1:0] shift_word;
    logic             cnvst_q;
    logic [RES_W-1:0] res_data_q;
    logic             res_sel_q;
    logic [PW-1:0]    pulse_tab [N_SEL];

    for (genvar g = 0; g < N_SEL; g++) begin : g_tab
        assign pulse_tab[g] = SEL_PULSES[g*PW +: PW];
    end

    function automatic logic [CNT_W-1:0] load_of(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    assign cmd_ready = (state_q == ST_IDLE);
    assign res_valid = (state_q == ST_DONE);
    assign accept    = cmd_valid && cmd_ready;
    assign rd_run    = (state_q == ST_READ);

    sar_sclk_gen #(
        .HALF  (SCLK_HALF),
        .NBITS (RES_W)
    ) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (rd_run),
        .sclk      (sclk),
        .rise_now  (rise_now),
        .last_fall (last_fall)
    );

    sar_shift_in #(
        .W (RES_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rise_now),
        .din     (sdata),
        .word    (shift_word)
    );

    // Next-state and counter logic
    always_comb begin
        state_n  = state_q;
        cnt_n    = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
        pulses_n = pulses_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (pulse_tab[cmd_sel] != '0) begin
                        state_n  = ST_SEL_HI;
                        cnt_n    = PULSE_LOAD;
                        pulses_n = pulse_tab[cmd_sel] - 1'b1;
                    end else begin
                        state_n = ST_ACQ;
                        cnt_n   = load_of(cfg_acq_cycles);
                    end
                end
            end
            ST_SEL_HI: begin
                if (cnt_q == '0) begin
                    state_n = ST_SEL_LO;
                    cnt_n   = PULSE_LOAD;
                end
            end
            ST_SEL_LO: begin
                if (cnt_q == '0) begin
                    if (pulses_q == '0) begin
                        state_n = ST_ACQ;
                        cnt_n   = load_of(acq_q);
                    end else begin
                        state_n  = ST_SEL_HI;
                        cnt_n    = PULSE_LOAD;
                        pulses_n = pulses_q - 1'b1;
                    end
                end
            end
            ST_ACQ: begin
                if (cnt_q == '0) begin
                    state_n = ST_CONV;
                    cnt_n   = load_of(conv_q);
                end
            end
            ST_CONV: begin
                if (cnt_q == '0) begin
                    state_n = ST_READ;
                end
            end
            ST_READ: begin
                if (last_fall) begin
                    state_n = ST_DONE;
                end
            end
            ST_DONE: begin
                if (res_ready) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register and latched command settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            pulses_q <= '0;
            acq_q    <= '0;
            conv_q   <= '0;
        end else begin
            state_q  <= state_n;
            cnt_q    <= cnt_n;
            pulses_q <= pulses_n;
            if (accept) begin
                acq_q  <= cfg_acq_cycles;
                conv_q <= cfg_conv_cycles;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnvst_q    <= 1'b0;
            res_data_q <= '0;
            res_sel_q  <= 1'b0;
        end else begin
            cnvst_q <= (state_n == ST_SEL_HI) || (state_n == ST_ACQ);
            if (last_fall) begin
                res_data_q <= shift_word;
            end
            if (accept) begin
                res_sel_q <= cmd_sel;
            end
        end
    end

    assign cnvst    = cnvst_q;
    assign res_data = res_data_q;
    assign res_sel  = res_sel_q;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!cnvst && !sclk && !res_valid));

    assert_busy_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_fall_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnvst) |-> (!sclk && !res_valid));

    assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_sel)));

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnvst && sclk));

endmodule

// File: tb/tb_sar_adc_host.sv
`timescale 1ns/1ps
module tb_sar_adc_host;
    localparam int RW   = 10;
    localparam int HALF = 2;
    localparam int CW   = 16;
    localparam int PC   = 2;
    localparam logic [7:0] SELP = {4'd1, 4'd0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic cmd_sel = 1'b0;
    logic [CW-1:0] cfg_acq = '0;
    logic [CW-1:0] cfg_conv = '0;
    logic cnvst, sclk;
    logic sdata = 1'b0;
    logic res_valid;
    logic res_ready = 1'b1;
    logic [RW-1:0] res_data;
    logic res_sel;

    always #2.5 clk = ~clk;

    sar_adc_host #(
        .RES_W(RW), .SCLK_HALF(HALF), .CNT_W(CW), .PULSE_CYC(PC), .PW(4), .SEL_PULSES(SELP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_sel(cmd_sel), .cfg_acq_cycles(cfg_acq), .cfg_conv_cycles(cfg_conv),
        .cnvst(cnvst), .sclk(sclk), .sdata(sdata), .res_valid(res_valid),
        .res_ready(res_ready), .res_data(res_data), .res_sel(res_sel)
    );

    int n_tests = 0;
    int n_fail = 0;
    int n_acc = 0;
    int n_res = 0;
    bit finished = 0;
    bit in_flight = 0;
    logic [1:0] exp_q[$];
    string tag_q[$];
    logic [RW-1:0] adc_word = '0;
    logic [RW-1:0] cur_word = '0;
    logic [RW-1:0] exp_data = '0;
    logic exp_sel = 1'b0;
    int model_delay = 1;
    int model_state = 0;
    int model_cnt = 0;
    int model_idx = 0;
    logic prev_cnvst = 1'b0;
    logic prev_sclk = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic int clamp1(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    task automatic finish_run();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Reference: build the expected start-line and clock waveform at acceptance
    always @(posedge clk) begin
        if (rst_n && !finished) begin
            if (cmd_valid && cmd_ready) begin
                int np;
                np = int'(SELP[cmd_sel*4 +: 4]);
                for (int p = 0; p < np; p++) begin
                    for (int i = 0; i < PC; i++) begin exp_q.push_back(2'b10); tag_q.push_back("R3"); end
                    for (int i = 0; i < PC; i++) begin exp_q.push_back(2'b00); tag_q.push_back("R3"); end
                end
                for (int i = 0; i < clamp1(int'(cfg_acq)); i++) begin
                    exp_q.push_back(2'b10); tag_q.push_back("R4/R11");
                end
                for (int i = 0; i < clamp1(int'(cfg_conv)); i++) begin
                    exp_q.push_back(2'b00); tag_q.push_back("R5/R11");
                end
                for (int b = 0; b < RW; b++) begin
                    for (int i = 0; i < HALF; i++) begin exp_q.push_back(2'b00); tag_q.push_back("R6"); end
                    for (int i = 0; i < HALF; i++) begin exp_q.push_back(2'b01); tag_q.push_back("R6"); end
                end
                exp_data    = adc_word;
                cur_word    = adc_word;
                exp_sel     = cmd_sel;
                model_delay = clamp1(int'(cfg_conv));
                in_flight   = 1;
                n_acc++;
            end
            if (res_valid && res_ready) begin
                in_flight = 0;
                n_res++;
            end
        end
    end

    // Per-cycle comparison and converter model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({cnvst, sclk} == e, t, "cnvst/sclk", int'({cnvst, sclk}), int'(e));
                chk(!cmd_ready && !res_valid, "R2", "busy ready/valid", int'({cmd_ready, res_valid}), 0);
                chk(!(cnvst && sclk), "R10", "overlap", int'({cnvst, sclk}), 0);
            end else if (in_flight) begin
                chk(res_valid == 1'b1, "R8", "res_valid", int'(res_valid), 1);
                chk(res_data == exp_data, "R7/R9", "res_data", int'(res_data), int'(exp_data));
                chk(res_sel == exp_sel, "R8/R11", "res_sel", int'(res_sel), int'(exp_sel));
                chk(!cnvst && !sclk, "R6", "lines idle in done", int'({cnvst, sclk}), 0);
            end else begin
                chk(cmd_ready && !res_valid && !cnvst && !sclk, "R1", "idle outputs",
                    int'({cmd_ready, res_valid, cnvst, sclk}), 8);
            end
            // converter model
            if (prev_cnvst && !cnvst) begin
                sdata = 1'b0;
                model_cnt = 0;
                model_state = 1;
            end else if (model_state == 1) begin
                model_cnt++;
                if (model_cnt == model_delay) begin
                    model_idx = RW - 1;
                    sdata = cur_word[model_idx];
                    model_state = 2;
                end
            end else if (model_state == 2) begin
                if (prev_sclk && !sclk) begin
                    if (model_idx == 0) begin
                        model_state = 0;
                        sdata = ~sdata;
                    end else begin
                        model_idx--;
                        sdata = cur_word[model_idx];
                    end
                end
            end else begin
                sdata = ~sdata;
            end
            prev_cnvst = cnvst;
            prev_sclk = sclk;
        end
    end

    task automatic issue(input bit sel, input int acq, input int conv, input logic [RW-1:0] w);
        int k;
        @(negedge clk);
        cmd_sel = sel;
        cfg_acq = CW'(acq);
        cfg_conv = CW'(conv);
        adc_word = w;
        cmd_valid = 1'b1;
        k = n_acc;
        while (n_acc == k) @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_result();
        while (in_flight) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk(!cnvst && !sclk && !res_valid && cmd_ready, "R1", "reset outputs",
            int'({cmd_ready, res_valid, cnvst, sclk}), 8);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        issue(1'b0, 3, 4, 10'h2A5);  wait_result();
        issue(1'b1, 5, 2, 10'h15A);  wait_result();
        issue(1'b0, 0, 0, 10'h3FF);  wait_result();
        issue(1'b1, 1, 1, 10'h000);  wait_result();
        issue(1'b0, 2, 6, 10'h001);  wait_result();

        // R8: result held while the consumer stalls; R9: data line toggles meanwhile
        res_ready = 1'b0;
        issue(1'b1, 4, 3, 10'h201);
        while (!res_valid) @(negedge clk);
        repeat (5) @(negedge clk);
        res_ready = 1'b1;
        wait_result();

        // R2 and R11: second command offered while busy with altered settings
        issue(1'b0, 6, 5, 10'h155);
        cmd_sel = 1'b1;
        cfg_acq = CW'(2);
        cfg_conv = CW'(1);
        adc_word = 10'h0F0;
        cmd_valid = 1'b1;
        begin
            int k;
            k = n_acc;
            while (n_acc == k) @(negedge clk);
        end
        cmd_valid = 1'b0;
        wait_result();

        repeat (6) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 50000, 0);
            finish_run();
        end
    end

endmodule